// File: doc/BRIEF.md
# Programmable SCL Clock Generator

This block produces the serial clock for an I2C bus master from the system clock. A five-bit divisor and a speed-select bit set the period of each SCL cycle. Standard speed uses a long period. Fast speed uses a shorter one, and one divisor value in fast speed gets a tighter timing with a shortened high phase. The transfer controller holds `run` high for as long as it wants clock pulses. Whenever the generator is stopped or set up wrongly, SCL rests high.

Two single-cycle strobes mark the moments the rest of the master needs. One fires in the middle of each high phase, where SDA is sampled. The other fires on the first cycle of each low phase, where SDA may change. Writing a new setting always restarts the waveform from a clean state. Divisor values below three are refused: the generator raises an error flag and emits nothing.

Top module: `scl_clkgen`

## Requirements
- R1: With `cfg_fast`=0 and divisor N (3..31), SCL repeats with a period of 8·N system cycles: 4·N cycles high, then 4·N cycles low.
- R2: With `cfg_fast`=1 and divisor N (3..31, N≠5), the period is 4·N cycles: 2·N high, then 2·N low.
- R3: With `cfg_fast`=1 and divisor 5, the period is 10 cycles: 4 high, then 6 low. The shorter high phase is made up by a longer low phase.
- R4: A stored divisor of 0, 1 or 2 sets `cfg_err`=1, holds SCL high and keeps both strobes low, whatever `run` does.
- R5: Sampling `run`=0 at a clock edge makes SCL high and both strobes low from that edge on. Sampling `run`=1 with a legal setting starts a high phase at the next edge.
- R6: A write (`cfg_we`=1 at a clock edge) stores `cfg_div` and `cfg_fast`. It also stops the waveform: SCL is high for the following cycle. If `run` stays high, a fresh full high phase starts one edge later, using the new setting.
- R7: `hi_mid_stb` is high for exactly one cycle per SCL period, at offset floor(H/2) into the high phase, where H is the high length. `lo_go_stb` is high for exactly one cycle, the first cycle of each low phase.
- R8: After reset the stored divisor is 0 and the speed bit is 0. So `cfg_err`=1, SCL is high, and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Setting write strobe |
| cfg_div | input | 5 | Divisor value to store |
| cfg_fast | input | 1 | Speed select to store (1 = fast) |
| run | input | 1 | Clock request from the transfer controller |
| scl_out | output | 1 | Generated SCL level |
| hi_mid_stb | output | 1 | Mid-high-phase sample strobe |
| lo_go_stb | output | 1 | Low-phase start strobe |
| cfg_err | output | 1 | Stored divisor is illegal |

## Verification
The bench tracks every output against its own model on every cycle, so a bad phase counter shows up quickly. If the counter skips a value or wraps at the wrong point, a wrong SCL level or a misplaced strobe appears within one SCL period. If the high-length or period arithmetic is wrong for one mode, the error shows at the first high-to-low edge in that mode. If the generator is not stopped or restarted when it should be, the error appears one cycle after the write or the `run` drop. At that cycle SCL must be high and the next high phase must have full length.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

  // Full SCL period in system cycles for a divisor and speed choice.
  function automatic int unsigned scl_period(
    input int unsigned ccr,
    input bit          fast,
    input int unsigned std_mult,
    input int unsigned fast_mult,
    input int unsigned spec_ccr,
    input int unsigned spec_hi,
    input int unsigned spec_lo
  );
    if (!fast)                 return std_mult * ccr;
    else if (ccr == spec_ccr)  return spec_hi + spec_lo;
    else                       return fast_mult * ccr;
  endfunction

  // Length of the high phase in system cycles.
  function automatic int unsigned scl_high(
    input int unsigned ccr,
    input bit          fast,
    input int unsigned std_mult,
    input int unsigned fast_mult,
    input int unsigned spec_ccr,
    input int unsigned spec_hi
  );
    if (!fast)                 return (std_mult * ccr) / 2;
    else if (ccr == spec_ccr)  return spec_hi;
    else                       return (fast_mult * ccr) / 2;
  endfunction

  function automatic bit ccr_ok(input int unsigned ccr, input int unsigned min_ccr);
    return ccr >= min_ccr;
  endfunction

endpackage

// File: rtl/scl_cfg_reg.sv
module scl_cfg_reg #(
  parameter int DIV_W   = 5,
  parameter int MIN_CCR = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [DIV_W-1:0] div_in,
  input  logic             fast_in,
  output logic [DIV_W-1:0] ccr_q,
  output logic             fast_q,
  output logic             legal,
  output logic             restart
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ccr_q  <= '0;
      fast_q <= 1'b0;
    end else if (we) begin
      ccr_q  <= div_in;
      fast_q <= fast_in;
    end
  end

  assign legal   = scl_gen_pkg::ccr_ok(32'(ccr_q), MIN_CCR);
  assign restart = we;
endmodule

// File: rtl/scl_phase_calc.sv
module scl_phase_calc #(
  parameter int DIV_W     = 5,
  parameter int CNT_W     = 8,
  parameter int STD_MULT  = 8,
  parameter int FAST_MULT = 4,
  parameter int SPEC_CCR  = 5,
  parameter int SPEC_HI   = 4,
  parameter int SPEC_LO   = 6
) (
  input  logic [DIV_W-1:0] ccr,
  input  logic             fast,
  output logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] high_len,
  output logic [CNT_W-1:0] mid_pt
);
  generate
    if (SPEC_CCR > 0) begin : g_special
      always_comb begin
        period   = CNT_W'(scl_gen_pkg::scl_period(32'(ccr), fast, STD_MULT, FAST_MULT,
                                                  SPEC_CCR, SPEC_HI, SPEC_LO));
        high_len = CNT_W'(scl_gen_pkg::scl_high(32'(ccr), fast, STD_MULT, FAST_MULT,
                                                SPEC_CCR, SPEC_HI));
      end
    end else begin : g_plain
      always_comb begin
        period   = fast ? CNT_W'(FAST_MULT * 32'(ccr)) : CNT_W'(STD_MULT * 32'(ccr));
        high_len = period >> 1;
      end
    end
  endgenerate

  assign mid_pt = high_len >> 1;
endmodule

// File: rtl/scl_divider.sv
module scl_divider #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             restart,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] high_len,
  input  logic [CNT_W-1:0] mid_pt,
  output logic [CNT_W-1:0] cnt,
  output logic             running,
  output logic             scl,
  output logic             hi_stb,
  output logic             lo_stb
);
  logic             running_d;
  logic             wrap;
  logic [CNT_W-1:0] cnt_d;

  assign running_d = go && !restart;
  assign wrap      = (cnt == period - CNT_W'(1));

  always_comb begin
    if (!running_d)   cnt_d = '0;
    else if (!running) cnt_d = '0;
    else if (wrap)    cnt_d = '0;
    else              cnt_d = cnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt     <= '0;
    end else begin
      running <= running_d;
      cnt     <= cnt_d;
    end
  end

  assign scl    = !running || (cnt < high_len);
  assign hi_stb = running && (cnt == mid_pt);
  assign lo_stb = running && (cnt == high_len);
endmodule

// File: rtl/scl_clkgen.sv
module scl_clkgen #(
  parameter int DIV_W     = 5,
  parameter int MIN_CCR   = 3,
  parameter int STD_MULT  = 8,
  parameter int FAST_MULT = 4,
  parameter int SPEC_CCR  = 5,
  parameter int SPEC_HI   = 4,
  parameter int SPEC_LO   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             cfg_fast,
  input  logic             run,
  output logic             scl_out,
  output logic             hi_mid_stb,
  output logic             lo_go_stb,
  output logic             cfg_err
);
  localparam int MAX_PERIOD = STD_MULT * ((1 << DIV_W) - 1);
  localparam int CNT_W      = $clog2(MAX_PERIOD + 1);

  logic [DIV_W-1:0] ccr_w;
  logic             fast_w;
  logic             legal_w;
  logic             restart_w;
  logic [CNT_W-1:0] period_w;
  logic [CNT_W-1:0] high_w;
  logic [CNT_W-1:0] mid_w;
  logic [CNT_W-1:0] cnt_w;
  logic             running_w;

  scl_cfg_reg #(.DIV_W(DIV_W), .MIN_CCR(MIN_CCR)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .div_in(cfg_div), .fast_in(cfg_fast),
    .ccr_q(ccr_w), .fast_q(fast_w), .legal(legal_w), .restart(restart_w)
  );

  scl_phase_calc #(
    .DIV_W(DIV_W), .CNT_W(CNT_W), .STD_MULT(STD_MULT), .FAST_MULT(FAST_MULT),
    .SPEC_CCR(SPEC_CCR), .SPEC_HI(SPEC_HI), .SPEC_LO(SPEC_LO)
  ) u_calc (
    .ccr(ccr_w), .fast(fast_w), .period(period_w), .high_len(high_w), .mid_pt(mid_w)
  );

  scl_divider #(.CNT_W(CNT_W)) u_div (
    .clk(clk), .rst_n(rst_n), .go(run && legal_w), .restart(restart_w),
    .period(period_w), .high_len(high_w), .mid_pt(mid_w),
    .cnt(cnt_w), .running(running_w), .scl(scl_out),
    .hi_stb(hi_mid_stb), .lo_stb(lo_go_stb)
  );

  assign cfg_err = !legal_w;
endmodule

// File: rtl/scl_clkgen_chk.sv
module scl_clkgen_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             cfg_we,
  input logic             scl_out,
  input logic             hi_mid_stb,
  input logic             lo_go_stb,
  input logic             cfg_err,
  input logic [CNT_W-1:0] cnt,
  input logic             running,
  input logic [CNT_W-1:0] period,
  input logic [CNT_W-1:0] high_len
);
  // R4
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (scl_out && !hi_mid_stb && !lo_go_stb));

  // R5
  stopped_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (scl_out && !hi_mid_stb && !lo_go_stb));

  // R5
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (cnt == '0));

  // R6
  write_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (!running && scl_out));

  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi_mid_stb && lo_go_stb));

  // R7
  low_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_go_stb |-> (!scl_out && $past(scl_out)));

  // R1
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (cnt < period));

  // R3
  high_not_longer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> ({1'b0, high_len} <= ({1'b0, period} >> 1)));
endmodule

bind scl_clkgen scl_clkgen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .cfg_we(cfg_we), .scl_out(scl_out),
  .hi_mid_stb(hi_mid_stb), .lo_go_stb(lo_go_stb), .cfg_err(cfg_err),
  .cnt(cnt_w), .running(running_w), .period(period_w), .high_len(high_w)
);

// File: tb/test_scl_clkgen.sv
`timescale 1ns/1ps
module test_scl_clkgen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [4:0] cfg_div = '0;
  logic       cfg_fast = 1'b0;
  logic       run = 1'b0;
  logic       scl_out, hi_mid_stb, lo_go_stb, cfg_err;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // reference model state
  int  m_ccr = 0;
  bit  m_fast = 0;
  bit  m_act = 0;
  int  m_pos = 0;
  bit  m_after_we = 0;

  scl_clkgen i_scl_clkgen (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_div(cfg_div), .cfg_fast(cfg_fast),
    .run(run), .scl_out(scl_out), .hi_mid_stb(hi_mid_stb), .lo_go_stb(lo_go_stb),
    .cfg_err(cfg_err)
  );

  always #10 clk = ~clk;

  function automatic int ref_high(int c, bit f);
    if (f && c == 5) return 4;
    return f ? 2 * c : 4 * c;
  endfunction

  function automatic int ref_low(int c, bit f);
    if (f && c == 5) return 6;
    return f ? 2 * c : 4 * c;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // model update at each edge, comparison 5 ns later
  always @(posedge clk) begin
    bit   nxt;
    int   per;
    int   hi;
    string tag;
    cycles++;
    if (!rst_n) begin
      m_ccr = 0; m_fast = 0; m_act = 0; m_pos = 0; m_after_we = 0;
    end else begin
      nxt = run && (m_ccr >= 3) && !cfg_we;
      per = ref_high(m_ccr, m_fast) + ref_low(m_ccr, m_fast);
      if (nxt && m_act) m_pos = (m_pos + 1) % per;
      else m_pos = 0;
      m_act = nxt;
      m_after_we = cfg_we;
      if (cfg_we) begin
        m_ccr = int'(cfg_div);
        m_fast = cfg_fast;
      end
    end
    #5;
    hi = ref_high(m_ccr, m_fast);
    if (!rst_n) tag = "R8";
    else if (m_ccr < 3) tag = "R4";
    else if (m_after_we) tag = "R6";
    else if (!m_act) tag = "R5";
    else if (!m_fast) tag = "R1";
    else if (m_ccr == 5) tag = "R3";
    else tag = "R2";
    check(tag, "scl_out", int'(scl_out), int'(!m_act || m_pos < hi));
    check(tag, "cfg_err", int'(cfg_err), int'(m_ccr < 3));
    check("R7", "hi_mid_stb", int'(hi_mid_stb), int'(m_act && m_pos == hi / 2));
    check("R7", "lo_go_stb", int'(lo_go_stb), int'(m_act && m_pos == hi));
    if (cycles > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  task automatic write_cfg(int d, bit f);
    @(negedge clk);
    cfg_we = 1'b1; cfg_div = 5'(d); cfg_fast = f;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // measure high and low lengths at the ports for one mode
  task automatic measure(string tag, int exp_hi, int exp_lo);
    int h = 0;
    int l = 0;
    while (scl_out !== 1'b0) @(negedge clk);
    while (scl_out === 1'b0) @(negedge clk);
    while (scl_out === 1'b1) begin h++; @(negedge clk); end
    while (scl_out === 1'b0) begin l++; @(negedge clk); end
    check(tag, "high length", h, exp_hi);
    check(tag, "low length", l, exp_lo);
  endtask

  initial begin
    idle(3);
    // R8 reset state
    check("R8", "reset scl_out", int'(scl_out), 1);
    check("R8", "reset cfg_err", int'(cfg_err), 1);
    rst_n = 1'b1;
    idle(2);
    // R4: run with illegal divisor
    run = 1'b1;
    idle(10);
    for (int d = 0; d < 3; d++) begin
      write_cfg(d, d[0]);
      idle(12);
      check("R4", "illegal scl held", int'(scl_out), 1);
    end
    // R1 standard speed
    write_cfg(3, 0);
    measure("R1", 12, 12);
    idle(30);
    write_cfg(31, 0);
    measure("R1", 124, 124);
    // R2 fast speed
    write_cfg(3, 1);
    measure("R2", 6, 6);
    write_cfg(6, 1);
    measure("R2", 12, 12);
    write_cfg(31, 1);
    measure("R2", 62, 62);
    // R3 special fast divisor
    write_cfg(5, 1);
    measure("R3", 4, 6);
    idle(25);
    // R5 stop mid-period, then restart
    run = 1'b0;
    idle(15);
    check("R5", "stopped scl", int'(scl_out), 1);
    run = 1'b1;
    idle(40);
    // R6 write during a low phase restarts with new setting
    write_cfg(4, 0);
    idle(20);
    while (scl_out !== 1'b0) @(negedge clk);
    idle(3);
    write_cfg(7, 1);
    idle(60);
    // R6 write while stopped
    run = 1'b0;
    write_cfg(10, 0);
    idle(5);
    run = 1'b1;
    idle(200);
    finish_run();
  end
endmodule